// File: doc/BRIEF.md
# MMU Control Register Command Unit

This unit sits between a processor's 32-bit register port and the memory-management machinery of a core that has separate instruction and data paths. It holds a small set of configuration registers: the first-level page-table base, four enable bits, per-side fault type and fault address, and a release word. Some addresses hold no value at all. A write to one of these command addresses becomes a single operation request, sent to one of five targets. The targets are the instruction TLB, the data TLB, the instruction cache, the data cache and the posted-write buffer.

Each command address has a fixed target, a fixed operation and a fixed blocking rule. For a blocking command the unit holds the processor stalled until the target acknowledges. Prefetch is the only non-blocking command, so the processor continues at once. While a prefetch request is still outstanding, the unit refuses any further command write, but reads and configuration writes still go through. The TLBs, caches, translation and write buffer are outside this block. Each one is seen only as a request/acknowledge pair, plus a shared operation code and a shared address bus.

Top module: `mmu_cmd_unit`

## Requirements
- R1: Writing word offset 0 stores bits 26:0 of the written value as the page-table base. A read of offset 0 returns that field with bits 31:27 as zero. `ptbase_o` presents the field shifted left by 13, so it is a 40-bit address aligned on 8 KB.
- R2: Writing word offset 1 stores bits 3:0 of the written value as the enables. Bit 3 enables the instruction TLB, bit 2 the data TLB, bit 1 the instruction cache and bit 0 the data cache. The stored value drives `mode_o` and is returned by a read of offset 1. Only an accepted write to offset 1 changes it.
- R3: A write of any value to offset 8 raises a flush request (op 0, address 0) to the instruction cache. The same write to offset 9 does the same for the data cache. Both commands are blocking.
- R4: The value written to offset 10 or offset 11 is a virtual address. It is sent zero-extended with op 1 to the instruction TLB (offset 10) or the data TLB (offset 11). The command is blocking.
- R5: The value written to offset 12 or offset 13 is a virtual address. It is sent zero-extended with op 1 to the instruction cache (offset 12) or the data cache (offset 13). The command is blocking.
- R6: The value written to offset 14 or offset 15 is a virtual address. It is sent with op 2 to the instruction cache (offset 14) or the data cache (offset 15), and `bus_stall` stays low. While that request is outstanding, a command write is stalled until the acknowledge, and a read or configuration write is accepted at once.
- R7: A write of any value to offset 16 raises a sync request (op 3, address 0) to the write buffer. The command is blocking.
- R8: The value written to offset 17 or offset 18 gives physical address bits 39:8. It is sent as the written value shifted left by 8, with op 4, to the instruction cache (offset 17) or the data cache (offset 18). The command is blocking.
- R9: A request rises in the cycle after its command write is accepted, with a blocking command also raising `bus_stall` in that cycle. `tgt_req`, `cmd_op` and `cmd_addr` stay stable until the selected target acknowledges, and the request and stall drop in the next cycle. A bus transfer is accepted only in a cycle with `bus_valid` high and `bus_stall` low. The `tgt_req` bits are 0 for the instruction TLB, 1 for the data TLB, 2 for the instruction cache, 3 for the data cache and 4 for the write buffer.
- R10: A pulse on `ifault_valid` or `dfault_valid` records the fault type and faulting address. The instruction-side type and address are read at offsets 2 and 3, and the data-side type and address at offsets 4 and 5. Processor writes to these offsets have no effect.
- R11: Offset 6 reads as the release word, with the revision parameter in bits 31:16 and the implementation index in bits 15:0. Writes to it have no effect.
- R12: Reads of command offsets and of unmapped offsets return zero. Read data appears on `bus_rdata` in the cycle after the read is accepted.
- R13: After reset, no request is raised, `bus_stall` is low, and the page-table base, the enables, the fault registers and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after accept |
| bus_stall | output | 1 | Processor must hold its access |
| ptbase_o | output | PA_W | Page-table base physical address |
| mode_o | output | 4 | TLB and cache enables |
| ifault_valid | input | 1 | Instruction-side fault capture strobe |
| ifault_type | input | FT_W | Instruction-side fault type |
| ifault_vaddr | input | 32 | Instruction-side faulting address |
| dfault_valid | input | 1 | Data-side fault capture strobe |
| dfault_type | input | FT_W | Data-side fault type |
| dfault_vaddr | input | 32 | Data-side faulting address |
| tgt_req | output | 5 | One-hot request per target |
| cmd_op | output | 3 | Operation code of the outstanding request |
| cmd_addr | output | PA_W | Address of the outstanding request |
| tgt_ack | input | 5 | Per-target completion acknowledge |

## Verification
The bench varies the acknowledge latency of each command and counts the stalled cycles. If a design released the stall one cycle early or late, or stalled on a prefetch, the count would be off. A command write is issued right behind an outstanding prefetch, which catches a design that overwrites the live request or loses the second command. A configuration write is attempted during a blocking stall; a design that accepted it early would update the enables too soon. Writes to the fault and release registers, and reads of command offsets, expose a decoder that lets read-only state be written or leaks a command value back onto the read data.

// File: rtl/mmu_cmd_pkg.sv
package mmu_cmd_pkg;

  localparam int DW   = 32;
  localparam int NTGT = 5;

  // target index inside the one-hot request vector
  localparam int T_ITLB   = 0;
  localparam int T_DTLB   = 1;
  localparam int T_ICACHE = 2;
  localparam int T_DCACHE = 3;
  localparam int T_WBUF   = 4;

  // register word offsets
  localparam int OFF_PTBASE   = 0;
  localparam int OFF_MODE     = 1;
  localparam int OFF_IFTYPE   = 2;
  localparam int OFF_IFADDR   = 3;
  localparam int OFF_DFTYPE   = 4;
  localparam int OFF_DFADDR   = 5;
  localparam int OFF_RELEASE  = 6;
  localparam int OFF_IC_FLUSH = 8;
  localparam int OFF_DC_FLUSH = 9;
  localparam int OFF_IT_INV   = 10;
  localparam int OFF_DT_INV   = 11;
  localparam int OFF_IC_INV   = 12;
  localparam int OFF_DC_INV   = 13;
  localparam int OFF_IC_PF    = 14;
  localparam int OFF_DC_PF    = 15;
  localparam int OFF_SYNC     = 16;
  localparam int OFF_IC_PAINV = 17;
  localparam int OFF_DC_PAINV = 18;

  typedef enum logic [2:0] {
    OP_FLUSH    = 3'd0,
    OP_INV_VA   = 3'd1,
    OP_PREFETCH = 3'd2,
    OP_SYNC     = 3'd3,
    OP_INV_PA   = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_VA   = 2'd1,
    AK_PA   = 2'd2
  } addr_kind_e;

  typedef struct packed {
    logic             hit;
    logic [NTGT-1:0]  tgt;
    cmd_op_e          op;
    logic             blocking;
    addr_kind_e       akind;
  } cmd_dec_t;

endpackage

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs #(
  parameter int PTB_W  = 27,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ptbase,
  input  logic              wr_mode,
  input  logic [PTB_W-1:0]  ptb_wdata,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [PTB_W-1:0]  ptbase_q,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptbase_q <= '0;
      mode_q   <= '0;
    end else begin
      if (wr_ptbase) ptbase_q <= ptb_wdata;
      if (wr_mode)   mode_q   <= mode_wdata;
    end
  end

endmodule

// File: rtl/mmu_fault_bank.sv
module mmu_fault_bank #(
  parameter int FT_W = 4,
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic [FT_W-1:0] type_in,
  input  logic [VA_W-1:0] addr_in,
  output logic [FT_W-1:0] type_q,
  output logic [VA_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
      addr_q <= '0;
    end else if (cap) begin
      type_q <= type_in;
      addr_q <= addr_in;
    end
  end

endmodule

// File: rtl/mmu_cmd_decode.sv
module mmu_cmd_decode
  import mmu_cmd_pkg::*;
#(
  parameter int BUS_AW = 5
) (
  input  logic [BUS_AW-1:0] addr,
  output cmd_dec_t          dec
);

  function automatic cmd_dec_t mk(input int t, input cmd_op_e op,
                                  input logic blk, input addr_kind_e ak);
    cmd_dec_t d;
    d.hit      = 1'b1;
    d.tgt      = NTGT'(1) << t;
    d.op       = op;
    d.blocking = blk;
    d.akind    = ak;
    return d;
  endfunction

  always_comb begin
    dec = '0;
    case (int'(addr))
      OFF_IC_FLUSH: dec = mk(T_ICACHE, OP_FLUSH,    1'b1, AK_NONE);
      OFF_DC_FLUSH: dec = mk(T_DCACHE, OP_FLUSH,    1'b1, AK_NONE);
      OFF_IT_INV:   dec = mk(T_ITLB,   OP_INV_VA,   1'b1, AK_VA);
      OFF_DT_INV:   dec = mk(T_DTLB,   OP_INV_VA,   1'b1, AK_VA);
      OFF_IC_INV:   dec = mk(T_ICACHE, OP_INV_VA,   1'b1, AK_VA);
      OFF_DC_INV:   dec = mk(T_DCACHE, OP_INV_VA,   1'b1, AK_VA);
      OFF_IC_PF:    dec = mk(T_ICACHE, OP_PREFETCH, 1'b0, AK_VA);
      OFF_DC_PF:    dec = mk(T_DCACHE, OP_PREFETCH, 1'b0, AK_VA);
      OFF_SYNC:     dec = mk(T_WBUF,   OP_SYNC,     1'b1, AK_NONE);
      OFF_IC_PAINV: dec = mk(T_ICACHE, OP_INV_PA,   1'b1, AK_PA);
      OFF_DC_PAINV: dec = mk(T_DCACHE, OP_INV_PA,   1'b1, AK_PA);
      default:      dec = '0;
    endcase
  end

endmodule

// File: rtl/mmu_cmd_issuer.sv
module mmu_cmd_issuer
  import mmu_cmd_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  cmd_dec_t        dec,
  input  logic [PA_W-1:0] issue_addr,
  input  logic            cmd_attempt,
  input  logic [NTGT-1:0] tgt_ack,
  output logic [NTGT-1:0] tgt_req,
  output logic [2:0]      cmd_op,
  output logic [PA_W-1:0] cmd_addr,
  output logic            stall
);

  logic [NTGT-1:0] req_q;
  cmd_op_e         op_q;
  logic [PA_W-1:0] addr_q;
  logic            blk_q;
  logic            ack_hit;

  assign ack_hit = |(req_q & tgt_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      op_q   <= OP_FLUSH;
      addr_q <= '0;
      blk_q  <= 1'b0;
    end else if (ack_hit) begin
      req_q  <= '0;
      blk_q  <= 1'b0;
    end else if (issue) begin
      req_q  <= dec.tgt;
      op_q   <= dec.op;
      addr_q <= issue_addr;
      blk_q  <= dec.blocking;
    end
  end

  // blocking work stalls everything; a live prefetch only holds back commands
  assign stall    = blk_q | ((|req_q) & cmd_attempt);
  assign tgt_req  = req_q;
  assign cmd_op   = op_q;
  assign cmd_addr = addr_q;

endmodule

// File: rtl/mmu_cmd_unit.sv
module mmu_cmd_unit
  import mmu_cmd_pkg::*;
#(
  parameter int          BUS_AW    = 5,
  parameter int          PA_W      = 40,
  parameter int          PT_ALIGN  = 13,
  parameter int          FT_W      = 4,
  parameter logic [15:0] REL_REV   = 16'h0002,
  parameter logic [15:0] IMPL_IDX  = 16'h1A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_stall,
  output logic [PA_W-1:0]   ptbase_o,
  output logic [3:0]        mode_o,
  input  logic              ifault_valid,
  input  logic [FT_W-1:0]   ifault_type,
  input  logic [31:0]       ifault_vaddr,
  input  logic              dfault_valid,
  input  logic [FT_W-1:0]   dfault_type,
  input  logic [31:0]       dfault_vaddr,
  output logic [4:0]        tgt_req,
  output logic [2:0]        cmd_op,
  output logic [PA_W-1:0]   cmd_addr,
  input  logic [4:0]        tgt_ack
);

  localparam int PTB_W    = PA_W - PT_ALIGN;
  localparam int PA_SHIFT = PA_W - DW;
  localparam int MODE_W   = 4;
  localparam int NSIDE    = 2;

  cmd_dec_t    dec;
  logic        accept;
  logic        wr_acc;
  logic        rd_acc;
  logic [PA_W-1:0] issue_addr;
  logic [PTB_W-1:0]  ptbase_q;
  logic [MODE_W-1:0] mode_q;
  logic [31:0] rd_val;
  logic [31:0] rdata_q;

  logic [NSIDE-1:0]           flt_cap;
  logic [NSIDE-1:0][FT_W-1:0] flt_tin;
  logic [NSIDE-1:0][FT_W-1:0] flt_tq;
  logic [NSIDE-1:0][DW-1:0]   flt_ain;
  logic [NSIDE-1:0][DW-1:0]   flt_aq;

  mmu_cmd_decode #(.BUS_AW(BUS_AW)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign accept = bus_valid & ~bus_stall;
  assign wr_acc = accept &  bus_write;
  assign rd_acc = accept & ~bus_write;

  always_comb begin
    case (dec.akind)
      AK_VA:   issue_addr = PA_W'(bus_wdata);
      AK_PA:   issue_addr = {bus_wdata, {PA_SHIFT{1'b0}}};
      default: issue_addr = '0;
    endcase
  end

  mmu_cmd_issuer #(.PA_W(PA_W)) u_iss (
    .clk         (clk),
    .rst         (rst),
    .issue       (wr_acc & dec.hit),
    .dec         (dec),
    .issue_addr  (issue_addr),
    .cmd_attempt (bus_valid & bus_write & dec.hit),
    .tgt_ack     (tgt_ack),
    .tgt_req     (tgt_req),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .stall       (bus_stall)
  );

  mmu_cfg_regs #(.PTB_W(PTB_W), .MODE_W(MODE_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_ptbase  (wr_acc && (int'(bus_addr) == OFF_PTBASE)),
    .wr_mode    (wr_acc && (int'(bus_addr) == OFF_MODE)),
    .ptb_wdata  (bus_wdata[PTB_W-1:0]),
    .mode_wdata (bus_wdata[MODE_W-1:0]),
    .ptbase_q   (ptbase_q),
    .mode_q     (mode_q)
  );

  assign flt_cap = {dfault_valid, ifault_valid};
  assign flt_tin = {dfault_type,  ifault_type};
  assign flt_ain = {dfault_vaddr, ifault_vaddr};

  for (genvar s = 0; s < NSIDE; s++) begin : g_flt
    mmu_fault_bank #(.FT_W(FT_W), .VA_W(DW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .cap     (flt_cap[s]),
      .type_in (flt_tin[s]),
      .addr_in (flt_ain[s]),
      .type_q  (flt_tq[s]),
      .addr_q  (flt_aq[s])
    );
  end

  always_comb begin
    case (int'(bus_addr))
      OFF_PTBASE:  rd_val = 32'(ptbase_q);
      OFF_MODE:    rd_val = 32'(mode_q);
      OFF_IFTYPE:  rd_val = 32'(flt_tq[0]);
      OFF_IFADDR:  rd_val = flt_aq[0];
      OFF_DFTYPE:  rd_val = 32'(flt_tq[1]);
      OFF_DFADDR:  rd_val = flt_aq[1];
      OFF_RELEASE: rd_val = {REL_REV, IMPL_IDX};
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign ptbase_o  = {ptbase_q, {PT_ALIGN{1'b0}}};
  assign mode_o    = mode_q;

endmodule

// File: rtl/mmu_cmd_unit_chk.sv
module mmu_cmd_unit_chk
  import mmu_cmd_pkg::*;
#(
  parameter int BUS_AW = 5,
  parameter int PA_W   = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_stall,
  input logic [31:0]       bus_rdata,
  input logic [3:0]        mode_o,
  input logic [4:0]        tgt_req,
  input logic [4:0]        tgt_ack,
  input logic [2:0]        cmd_op,
  input logic [PA_W-1:0]   cmd_addr
);

  logic acc_w, acc_r, ack_hit, busy;
  assign acc_w   = bus_valid & ~bus_stall &  bus_write;
  assign acc_r   = bus_valid & ~bus_stall & ~bus_write;
  assign ack_hit = |(tgt_req & tgt_ack);
  assign busy    = |tgt_req;

  p_req_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_req));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack_hit) |=> ($stable(tgt_req) && $stable(cmd_op) && $stable(cmd_addr)));

  p_req_release_r9: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> (tgt_req == '0 && !bus_stall));

  p_issue_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_w && int'(bus_addr) >= OFF_IC_FLUSH && int'(bus_addr) <= OFF_DC_PAINV) |=> busy);

  p_block_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_op != 3'(OP_PREFETCH)) |-> bus_stall);

  p_pf_nostall_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_op == 3'(OP_PREFETCH) && !bus_valid) |-> !bus_stall);

  p_pa_align_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_op == 3'(OP_INV_PA)) |-> (cmd_addr[PA_W-33:0] == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(acc_w && int'(bus_addr) == OFF_MODE) |=> $stable(mode_o));

  p_cmd_read_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_r && int'(bus_addr) >= OFF_IC_FLUSH) |=> (bus_rdata == '0));

endmodule

bind mmu_cmd_unit mmu_cmd_unit_chk #(.BUS_AW(BUS_AW), .PA_W(PA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_stall (bus_stall),
  .bus_rdata (bus_rdata),
  .mode_o    (mode_o),
  .tgt_req   (tgt_req),
  .tgt_ack   (tgt_ack),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr)
);

// File: tb/test_mmu_cmd_unit.sv
module test_mmu_cmd_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_stall;
  logic [39:0] ptbase_o;
  logic [3:0]  mode_o;
  logic        ifault_valid = 1'b0;
  logic [3:0]  ifault_type  = '0;
  logic [31:0] ifault_vaddr = '0;
  logic        dfault_valid = 1'b0;
  logic [3:0]  dfault_type  = '0;
  logic [31:0] dfault_vaddr = '0;
  logic [4:0]  tgt_req;
  logic [2:0]  cmd_op;
  logic [39:0] cmd_addr;
  logic [4:0]  tgt_ack = '0;

  mmu_cmd_unit i_mmu_cmd_unit (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall),
    .ptbase_o(ptbase_o), .mode_o(mode_o),
    .ifault_valid(ifault_valid), .ifault_type(ifault_type), .ifault_vaddr(ifault_vaddr),
    .dfault_valid(dfault_valid), .dfault_type(dfault_type), .dfault_vaddr(dfault_vaddr),
    .tgt_req(tgt_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .tgt_ack(tgt_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [4:0]  tgt;
    logic [2:0]  op;
    logic [39:0] addr;
    bit          blk;
    string       tag;
  } exp_cmd_t;

  exp_cmd_t    cq[$];
  logic [31:0] rq_val[$];
  string       rq_tag[$];
  int checks   = 0;
  int failures = 0;
  int ack_delay = 0;
  int cur_delay = 0;
  int ack_cnt   = 0;
  bit seen      = 0;
  bit done      = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model: acknowledges the live request after a per-command delay
  always @(negedge clk) begin
    if (rst || tgt_req == '0) begin
      ack_cnt = 0;
      tgt_ack = '0;
    end else begin
      if (ack_cnt == 0) cur_delay = ack_delay;
      tgt_ack = (ack_cnt == cur_delay) ? tgt_req : '0;
      ack_cnt++;
    end
  end

  // command monitor: compare each new request against the scoreboard
  always @(negedge clk) begin
    if (rst || tgt_req == '0) seen = 0;
    else if (!seen) begin
      seen = 1;
      if (cq.size() == 0) check(1'b0, "R9", "unexpected request", 64'(tgt_req), 64'h0);
      else begin
        exp_cmd_t e;
        e = cq.pop_front();
        check(tgt_req == e.tgt, e.tag, "target", 64'(tgt_req), 64'(e.tgt));
        check(cmd_op == e.op, e.tag, "op", 64'(cmd_op), 64'(e.op));
        check(cmd_addr == e.addr, e.tag, "addr", 64'(cmd_addr), 64'(e.addr));
        if (e.blk || !bus_valid)
          check(bus_stall == e.blk, e.tag, "stall on issue", 64'(bus_stall), 64'(e.blk));
      end
    end
  end

  // read monitor
  always @(negedge clk) begin
    while (!rst && rq_val.size() > 0) begin
      logic [31:0] ev;
      string t;
      ev = rq_val.pop_front();
      t  = rq_tag.pop_front();
      check(bus_rdata == ev, t, "read data", 64'(bus_rdata), 64'(ev));
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    waits = 0;
    #1;
    while (bus_stall) begin waits++; @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    while (bus_stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rq_val.push_back(exp);
    rq_tag.push_back(tag);
    bus_valid = 1'b0;
  endtask

  task automatic cmd(input logic [4:0] a, input logic [31:0] d, input logic [4:0] tgt,
                     input logic [2:0] op, input logic [39:0] addr, input bit blk,
                     input int dly, input string tag);
    exp_cmd_t e;
    int w;
    int n;
    e.tgt = tgt; e.op = op; e.addr = addr; e.blk = blk; e.tag = tag;
    ack_delay = dly;
    cq.push_back(e);
    bus_wr(a, d, w);
    n = 0;
    @(negedge clk); #1;
    while (bus_stall) begin n++; @(negedge clk); #1; end
    check(n == (blk ? dly + 1 : 0), tag, "stalled cycles", 64'(n), 64'(blk ? dly + 1 : 0));
  endtask

  initial begin
    int w;
    exp_cmd_t e;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(bus_stall == 1'b0, "R13", "stall", 64'(bus_stall), 64'h0);
    check(tgt_req == '0, "R13", "request", 64'(tgt_req), 64'h0);
    check(bus_rdata == '0, "R13", "rdata", 64'(bus_rdata), 64'h0);
    check(mode_o == '0, "R13", "mode", 64'(mode_o), 64'h0);
    check(ptbase_o == '0, "R13", "ptbase", 64'(ptbase_o), 64'h0);
    bus_rd(5'd3, 32'h0, "R13");

    // R1 page-table base
    bus_wr(5'd0, 32'hFFFF_FFFF, w);
    bus_rd(5'd0, 32'h07FF_FFFF, "R1");
    check(ptbase_o == 40'hFF_FFFF_E000, "R1", "ptbase_o all ones", 64'(ptbase_o), 64'hFF_FFFF_E000);
    bus_wr(5'd0, 32'h0000_0ABC, w);
    check(ptbase_o == 40'h00_0157_8000, "R1", "ptbase_o", 64'(ptbase_o), 64'h0157_8000);

    // R2 enables
    bus_wr(5'd1, 32'hFFFF_FFF5, w);
    bus_rd(5'd1, 32'h5, "R2");
    check(mode_o == 4'h5, "R2", "mode_o", 64'(mode_o), 64'h5);
    bus_wr(5'd1, 32'h8, w);
    check(mode_o == 4'h8, "R2", "itlb enable only", 64'(mode_o), 64'h8);

    // R11 release word, write ignored
    bus_rd(5'd6, 32'h0002_1A3C, "R11");
    bus_wr(5'd6, 32'h0, w);
    bus_rd(5'd6, 32'h0002_1A3C, "R11");

    // R12 unmapped and command offsets read zero
    bus_rd(5'd7,  32'h0, "R12");
    bus_rd(5'd12, 32'h0, "R12");
    bus_rd(5'd18, 32'h0, "R12");
    bus_rd(5'd31, 32'h0, "R12");

    // R10 fault capture
    @(negedge clk);
    ifault_valid = 1'b1; ifault_type = 4'h9; ifault_vaddr = 32'hDEAD_BEE0;
    dfault_valid = 1'b1; dfault_type = 4'h3; dfault_vaddr = 32'h0000_1004;
    @(negedge clk);
    ifault_valid = 1'b0; dfault_valid = 1'b0;
    bus_rd(5'd2, 32'h9, "R10");
    bus_rd(5'd3, 32'hDEAD_BEE0, "R10");
    bus_rd(5'd4, 32'h3, "R10");
    bus_rd(5'd5, 32'h0000_1004, "R10");
    bus_wr(5'd3, 32'hFFFF_FFFF, w);
    bus_wr(5'd4, 32'hFFFF_FFFF, w);
    bus_rd(5'd3, 32'hDEAD_BEE0, "R10");
    bus_rd(5'd4, 32'h3, "R10");

    // R3 flushes
    cmd(5'd8, 32'h1234_5678, 5'b00100, 3'd0, 40'h0, 1'b1, 2, "R3");
    cmd(5'd9, 32'h0,         5'b01000, 3'd0, 40'h0, 1'b1, 0, "R3");
    // R4 TLB invalidation
    cmd(5'd10, 32'h8000_1234, 5'b00001, 3'd1, 40'h00_8000_1234, 1'b1, 1, "R4");
    cmd(5'd11, 32'hFFFF_F000, 5'b00010, 3'd1, 40'h00_FFFF_F000, 1'b1, 3, "R4");
    // R5 cache invalidation by virtual address
    cmd(5'd12, 32'h0040_0020, 5'b00100, 3'd1, 40'h00_0040_0020, 1'b1, 2, "R5");
    cmd(5'd13, 32'h0040_0040, 5'b01000, 3'd1, 40'h00_0040_0040, 1'b1, 5, "R5");
    // R7 sync
    cmd(5'd16, 32'hAAAA_AAAA, 5'b10000, 3'd3, 40'h0, 1'b1, 4, "R7");
    // R8 physical invalidation
    cmd(5'd17, 32'h1234_5678, 5'b00100, 3'd4, 40'h12_3456_7800, 1'b1, 1, "R8");
    cmd(5'd18, 32'hFFFF_FFFF, 5'b01000, 3'd4, 40'hFF_FFFF_FF00, 1'b1, 0, "R8");

    // R6 prefetch: no stall, configuration write accepted at once
    cmd(5'd15, 32'h0000_3000, 5'b01000, 3'd2, 40'h00_0000_3000, 1'b0, 3, "R6");
    bus_wr(5'd1, 32'h3, w);
    check(w == 0, "R6", "config write waits during prefetch", 64'(w), 64'h0);
    check(mode_o == 4'h3, "R6", "mode after write", 64'(mode_o), 64'h3);
    repeat (4) @(negedge clk);

    // R6 command right behind a prefetch waits for its acknowledge
    cmd(5'd14, 32'h0000_5000, 5'b00100, 3'd2, 40'h00_0000_5000, 1'b0, 4, "R6");
    e.tgt = 5'b10000; e.op = 3'd3; e.addr = 40'h0; e.blk = 1'b1; e.tag = "R6";
    cq.push_back(e);
    bus_wr(5'd16, 32'h0, w);
    check(w == 4, "R6", "command wait behind prefetch", 64'(w), 64'h4);
    ack_delay = 1;
    repeat (5) @(negedge clk);

    // R9 configuration write held off during a blocking command
    e.tgt = 5'b10000; e.op = 3'd3; e.addr = 40'h0; e.blk = 1'b1; e.tag = "R9";
    cq.push_back(e);
    ack_delay = 6;
    bus_wr(5'd16, 32'h0, w);
    check(mode_o == 4'h3, "R9", "mode before stalled write", 64'(mode_o), 64'h3);
    bus_wr(5'd1, 32'hC, w);
    check(w == 7, "R9", "stalled write waits", 64'(w), 64'h7);
    check(mode_o == 4'hC, "R9", "mode after stall", 64'(mode_o), 64'hC);
    check(tgt_req == '0, "R9", "request dropped", 64'(tgt_req), 64'h0);

    repeat (10) @(negedge clk);
    check(cq.size() == 0, "R9", "all commands issued", 64'(cq.size()), 64'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule